// File: doc/BRIEF.md
# Parallel-to-Serial Word Serializer

This block turns a stream of fixed-width parallel words into a single serial bit stream, one bit per cycle of the fast serial clock. It makes its own word-rate clock by dividing the serial clock by the word width (16 by default). Upstream logic can use that divided clock to present the next word, for example in a counter-clocked transfer where the word clock is sent back to the data source. A word is captured on the same edge where the divided clock rises. The block then shifts the word out with no idle cycle between the last bit of one word and the first bit of the next.

A static select picks which end of the word goes out first: the lowest bit or the highest bit. An active-low squelch input forces the line to zero without stopping the internal word sequence, so the stream picks up in step when squelch is released. A small two-state controller holds the line at zero after reset until the first word has been captured. The states are PH_PRIME (waiting for the first load) and PH_STREAM (transmitting). The only transition, PH_PRIME to PH_STREAM, is taken on the first load edge. PH_STREAM holds until reset.

Top module: `word_serializer`

## Requirements
- R1: A synchronous active-low reset clears the divide counter. While reset is applied and for the 16 cycles after it is released, `ser_out` is 0 and the block is in PH_PRIME. `word_clk` is 1 in the first cycle after the reset edge.
- R2: `word_clk` has a period of 16 serial cycles. It is high for 8 cycles and low for 8. It rises on the same clock edge that loads a word.
- R3: `word_in` and `msb_first` are sampled only on the rising clock edge at which `word_clk` goes from 0 to 1. The first such edge is the 16th edge after reset is released, and every 16th edge follows.
- R4: With `msb_first` = 0 at the load edge, bit 0 of the word appears on `ser_out` in the cycle after the load edge. Bits 1, 2, ... 15 follow in the next cycles, in ascending order.
- R5: With `msb_first` = 1 at the load edge, bit 15 appears first. Bits 14 down to 0 follow in descending order.
- R6: Words are back to back. The first bit of a new word is on `ser_out` in the cycle directly after the cycle that carried the last bit of the previous word. The bit order may differ from one word to the next.
- R7: While `squelch_n` is 0, `ser_out` is 0 in that same cycle, with no clock delay.
- R8: Squelch does not pause the shift sequence. When `squelch_n` returns to 1, `ser_out` shows the bit the stream would carry in that cycle had squelch never been applied.
- R9: Changes to `word_in` or `msb_first` between load edges do not affect the word currently being shifted out.
- R10: With squelch released, `ser_out` changes only on the rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 16 | Parallel word, captured on the word-load edge |
| msb_first | input | 1 | Bit order: 0 sends bit 0 first, 1 sends bit 15 first |
| squelch_n | input | 1 | Active-low squelch; 0 forces `ser_out` to 0 |
| ser_out | output | 1 | Serial data line |
| word_clk | output | 1 | Serial clock divided by 16, 50% duty, rises on load |

## Verification
The bench targets the word seam. An off-by-one in the divider or the load timing would either repeat a bit or insert a stale bit between words, and the per-cycle comparison would show a one-bit slip. It changes `word_in` and the order select on every cycle. A design that samples them anywhere other than the load edge would therefore corrupt words in the middle of transmission. Squelch is toggled at random. A design that freezes the shifter while squelched would resume out of alignment, and one that registers the gate would leak a bit for one cycle. A reset in the middle of the stream confirms the return to the quiet PH_PRIME behaviour and to the word-clock phase.

// File: rtl/wser_pkg.sv
package wser_pkg;
    typedef enum logic {
        PH_PRIME  = 1'b0,
        PH_STREAM = 1'b1
    } phase_t;
endpackage

// File: rtl/wser_divider.sv
module wser_divider #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic wclk_o
);
    localparam int CW   = $clog2(W);
    localparam int HALF = W / 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    assign load_o  = (cnt_q == CW'(W - 1));
    assign cnt_nxt = load_o ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wclk_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_nxt;
            wclk_o <= (cnt_nxt < CW'(HALF));
        end
    end
endmodule

// File: rtl/wser_shifter.sv
module wser_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         msb_first,
    input  logic [W-1:0] word_in,
    output logic         bit_o
);
    logic [W-1:0] ordered;
    logic [W-1:0] sh_q;

    // Reorder at capture so the shift direction never changes.
    for (genvar i = 0; i < W; i++) begin : g_order
        assign ordered[i] = msb_first ? word_in[W-1-i] : word_in[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= ordered;
        end else begin
            sh_q <= {1'b0, sh_q[W-1:1]};
        end
    end

    assign bit_o = sh_q[0];
endmodule

// File: rtl/word_serializer.sv
module word_serializer
    import wser_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] word_in,
    input  logic         msb_first,
    input  logic         squelch_n,
    output logic         ser_out,
    output logic         word_clk
);
    logic   load;
    logic   line_bit;
    phase_t phase;
    phase_t phase_nxt;

    wser_divider #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_o (load),
        .wclk_o (word_clk)
    );

    wser_shifter #(.W(W)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .msb_first (msb_first),
        .word_in   (word_in),
        .bit_o     (line_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_PRIME;
        else        phase <= phase_nxt;
    end

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_PRIME:  if (load) phase_nxt = PH_STREAM;
            PH_STREAM: phase_nxt = PH_STREAM;
            default:   phase_nxt = PH_PRIME;
        endcase
    end

    always_comb begin
        ser_out = 1'b0;
        unique case (phase)
            PH_PRIME:  ser_out = 1'b0;
            PH_STREAM: ser_out = line_bit & squelch_n;
            default:   ser_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/wser_checker.sv
module wser_checker
    import wser_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] word_in,
    input logic         msb_first,
    input logic         squelch_n,
    input logic         ser_out,
    input logic         word_clk,
    input logic         load,
    input phase_t       phase
);
    localparam int HALF = W / 2;
    localparam int RW   = $clog2(W) + 1;

    logic          armed;
    logic          seen;
    logic          prev_wclk;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            seen      <= 1'b0;
            prev_wclk <= 1'b1;
            run       <= '0;
        end else begin
            armed     <= 1'b1;
            prev_wclk <= word_clk;
            if (word_clk != prev_wclk) begin
                run  <= RW'(1);
                seen <= 1'b1;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    AST_WCLK_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && seen && (word_clk != prev_wclk)) |-> (run == RW'(HALF))); // R2

    AST_WCLK_RISES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && load) |=> $rose(word_clk)); // R2

    AST_FIRST_BIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed) && $past(load) && squelch_n) |->
        (ser_out == ($past(msb_first) ? $past(word_in[W-1]) : $past(word_in[0])))); // R4

    AST_SQUELCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!squelch_n) |-> (!ser_out)); // R7

    AST_STREAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && phase == PH_STREAM) |=> (phase == PH_STREAM)); // R1

    AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRIME) |-> (!ser_out)); // R1
endmodule

bind word_serializer wser_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_in   (word_in),
    .msb_first (msb_first),
    .squelch_n (squelch_n),
    .ser_out   (ser_out),
    .word_clk  (word_clk),
    .load      (load),
    .phase     (phase)
);

// File: tb/word_serializer_tb.sv
`timescale 1ns/1ps
module word_serializer_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         msb_first = 1'b0;
    logic         squelch_n = 1'b1;
    logic         ser_out;
    logic         word_clk;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state
    bit m_q[$];
    int m_cnt = 0;

    always #4 clk = ~clk;

    word_serializer #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_in   (word_in),
        .msb_first (msb_first),
        .squelch_n (squelch_n),
        .ser_out   (ser_out),
        .word_clk  (word_clk)
    );

    // Behavioural model: a bit queue refilled every 16th edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_q.delete();
        end else begin
            if (m_cnt == W - 1) begin
                m_q.delete();
                for (int i = 0; i < W; i++)
                    m_q.push_back(msb_first ? word_in[W-1-i] : word_in[i]);
            end else if (m_q.size() > 0) begin
                void'(m_q.pop_front());
            end
            m_cnt = (m_cnt + 1) % W;
        end
    end

    always @(negedge clk) begin
        if (checking && !done) begin
            bit exp_out;
            bit exp_wclk;
            exp_out  = (m_q.size() > 0) ? (m_q[0] & squelch_n) : 1'b0;
            exp_wclk = (m_cnt < W / 2);
            n_checks++;
            if (ser_out !== exp_out) begin
                n_fail++;
                $display("FAIL %s ser_out actual=%b expected=%b at %0t", tag, ser_out, exp_out, $time);
            end
            n_checks++;
            if (word_clk !== exp_wclk) begin
                n_fail++;
                $display("FAIL R2 word_clk actual=%b expected=%b at %0t", word_clk, exp_wclk, $time);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // mode: 0 fixed word, 1 random word each cycle; ord: 0/1 fixed, 2 random
    task automatic run_words(input int nwords, input int mode, input logic [W-1:0] fixed,
                             input int ord, input bit sq_rand);
        for (int c = 0; c < nwords * W; c++) begin
            word_in   = (mode == 0) ? fixed : W'($urandom);
            msb_first = (ord == 2) ? 1'($urandom) : 1'(ord);
            squelch_n = sq_rand ? 1'($urandom) : 1'b1;
            if (sq_rand) tag = squelch_n ? "R8" : "R7";
            step();
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0;
        step();
        checking = 1'b1;           // R1: reset state checked from here
        repeat (3) step();
        rst_n = 1'b1;
        tag = "R1";
        run_words(1, 0, 16'hA5C3, 0, 1'b0);   // R1 quiet prime window, R3 first load
        tag = "R4";
        run_words(2, 0, 16'h0001, 0, 1'b0);   // R4 single low bit
        run_words(20, 1, '0, 0, 1'b0);        // R4 random words, R9 mid-word changes
        tag = "R5";
        run_words(2, 0, 16'h8000, 1, 1'b0);   // R5 single high bit
        run_words(20, 1, '0, 1, 1'b0);        // R5 random words
        tag = "R6";
        run_words(2, 0, 16'hFFFF, 2, 1'b0);   // R6 seam with all ones
        run_words(20, 1, '0, 2, 1'b0);        // R6 order changing per word, R3 sampling
        run_words(20, 1, '0, 2, 1'b1);        // R7 squelch low, R8 resume alignment
        tag = "R9";
        run_words(20, 1, '0, 2, 1'b0);        // R9 inputs churn between loads
        tag = "R1";
        rst_n = 1'b0;                         // R1 reset in the middle of a word
        repeat (3) step();
        rst_n = 1'b1;
        run_words(1, 1, '0, 2, 1'b0);         // R1 prime window after reset
        tag = "R10";
        run_words(4, 1, '0, 2, 1'b0);         // R10 outputs stable between edges
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule